// File: doc/BRIEF.md
# Double-Buffered Multi-Channel 8-bit PWM Generator

This block produces one pulse-width-modulated output per channel from a shared free-running timer. Each channel compares the timer's low byte with its own active duty value. The output is registered and is driven high while the count is at or above that value. Software never changes the active value directly. It writes a staging register, and the hardware moves the staged value into the active register at the instant the timer low byte steps from all-ones to zero. A duty change therefore always starts at the beginning of a period, and no period ever contains a partial pulse.

Every channel has its own enable, staging write strobe, active value and output. All channels share the timer input and one write-data bus. Any subset of channels can run at once. The timer may advance on every clock or be held for several clocks, because only a change of value from all-ones to zero counts as a period boundary. While a channel is disabled, its output is held low and its active value is frozen. Its staging register still accepts writes.

Top module: `pwm8_dbuf`

## Requirements
- R1: Reset drives every output to 0 and clears every active and staging register to 0. A channel that is enabled after reset with no write is therefore high for the whole first period.
- R2: With a channel enabled, its output in the clock after a timer value is presented is 1 when that value is greater than or equal to the active duty value, and 0 otherwise.
- R3: A staging write changes neither the active value nor the output for the rest of the current period.
- R4: At the clock where the timer low byte changes from 255 to 0 with the channel enabled, the staged value becomes active, and that clock's output is already computed with it.
- R5: An active duty value d gives exactly 256 − d high counts per period. d = 0 gives a constant high output.
- R6: While a channel's enable is 0, its output is 0 from the next clock on. A period boundary in that time does not reload its active value, and the staging register keeps any value written to it.
- R7: When a staging write and a period boundary fall on the same clock, the value copied is the one staged before that clock. The newly written value becomes active at the following boundary.
- R8: Timer changes other than 255→0 do not reload the active value. These include a jump to 0 from another value, and a value held for several clocks.
- R9: Channels are independent. A write or an enable on one channel does not affect another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk_i |
| cnt_i | input | W (8) | Low byte of the shared timer |
| en_i | input | CH (2) | Per-channel PWM enable |
| wr_en_i | input | CH (2) | Per-channel staging register write strobe |
| wr_data_i | input | W (8) | Duty value to stage |
| pwm_o | output | CH (2) | Registered PWM outputs |

## Verification
A wrong active value shows as a wrong number of high counts in the very next period, and as an edge at the wrong count one clock after that count is presented. A reload at the wrong moment shows up in the same period as the write that triggered it: the output edge moves earlier, or a pulse is cut short, before any boundary is reached. A missed reload shows as the old duty continuing into the period that should carry the new one. A broken enable gate shows as a high level on a disabled channel one clock after the enable falls.

// File: rtl/pwm8_dbuf_pkg.sv
`timescale 1ns/1ps
package pwm8_dbuf_pkg;
  localparam int unsigned DUTY_W_DEF = 8;
  localparam int unsigned CHAN_DEF   = 2;

  // per-channel control strobes gathered at the top
  typedef struct packed {
    logic run;
    logic stage_wr;
  } chan_ctl_t;
endpackage

// File: rtl/pwm8_wrap_det.sv
`timescale 1ns/1ps
module pwm8_wrap_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] cnt_i,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_TOP = '1;

  logic [W-1:0] last_q;
  logic [W-1:0] last_d;

  always_comb begin
    last_d = cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) last_q <= '0;
    else          last_q <= last_d;
  end

  // a boundary is the single step from the top value to zero
  assign wrap_o = (last_q == CNT_TOP) && (cnt_i == '0);
endmodule

// File: rtl/pwm8_duty_reg.sv
`timescale 1ns/1ps
module pwm8_duty_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  input  logic         wrap_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] stg_o,
  output logic [W-1:0] duty_eff_o
);
  logic [W-1:0] act_q, act_d;
  logic [W-1:0] stg_q, stg_d;
  logic         load_act;

  assign load_act = en_i & wrap_i;

  always_comb begin
    stg_d = stg_q;
    if (wr_en_i) stg_d = wr_data_i;
    act_d = act_q;
    if (load_act) act_d = stg_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      act_q <= '0;
      stg_q <= '0;
    end else begin
      act_q <= act_d;
      stg_q <= stg_d;
    end
  end

  // the boundary cycle already compares against the incoming value
  assign duty_eff_o = load_act ? stg_q : act_q;
  assign act_o      = act_q;
  assign stg_o      = stg_q;
endmodule

// File: rtl/pwm8_cmp_out.sv
`timescale 1ns/1ps
module pwm8_cmp_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic pwm_q, pwm_d;

  always_comb begin
    pwm_d = en_i && (cnt_i >= duty_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pwm_q <= 1'b0;
    else          pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm8_dbuf.sv
`timescale 1ns/1ps
module pwm8_dbuf
  import pwm8_dbuf_pkg::*;
#(
  parameter int unsigned W  = DUTY_W_DEF,
  parameter int unsigned CH = CHAN_DEF
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic [W-1:0]  cnt_i,
  input  logic [CH-1:0] en_i,
  input  logic [CH-1:0] wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [CH-1:0] pwm_o
);
  logic                  wrap;
  chan_ctl_t [CH-1:0]    ctl;
  logic [CH-1:0][W-1:0]  act_duty;
  logic [CH-1:0][W-1:0]  stg_duty;
  logic [CH-1:0][W-1:0]  eff_duty;

  pwm8_wrap_det #(.W(W)) u_wrap (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .cnt_i   (cnt_i),
    .wrap_o  (wrap)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign ctl[c].run      = en_i[c];
    assign ctl[c].stage_wr = wr_en_i[c];

    pwm8_duty_reg #(.W(W)) u_duty (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .en_i       (ctl[c].run),
      .wrap_i     (wrap),
      .wr_en_i    (ctl[c].stage_wr),
      .wr_data_i  (wr_data_i),
      .act_o      (act_duty[c]),
      .stg_o      (stg_duty[c]),
      .duty_eff_o (eff_duty[c])
    );

    pwm8_cmp_out #(.W(W)) u_out (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .en_i    (ctl[c].run),
      .cnt_i   (cnt_i),
      .duty_i  (eff_duty[c]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm8_dbuf_chk.sv
`timescale 1ns/1ps
module pwm8_dbuf_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned CH = 2
) (
  input logic                 clk_i,
  input logic                 rst_n_i,
  input logic [W-1:0]         cnt_i,
  input logic [CH-1:0]        en_i,
  input logic [CH-1:0]        wr_en_i,
  input logic [CH-1:0]        pwm_o,
  input logic [CH-1:0][W-1:0] act_i,
  input logic [CH-1:0][W-1:0] stg_i
);
  logic [W-1:0] seen_q;
  logic         bnd;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) seen_q <= '0;
    else          seen_q <= cnt_i;
  end

  assign bnd = (&seen_q) && (cnt_i == '0);

  always_comb begin
    if (!rst_n_i) assert_reset_low_R1: assert (pwm_o == '0);
  end

  for (genvar c = 0; c < CH; c++) begin : g_chk
    assert_compare_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i[c] && !bnd) |=> (pwm_o[c] == ($past(cnt_i) >= $past(act_i[c]))));

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(en_i[c] && bnd) |=> $stable(act_i[c]));

    assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i[c] && bnd) |=> (act_i[c] == $past(stg_i[c])));

    assert_zero_high_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i[c] && !bnd && act_i[c] == '0) |=> pwm_o[c]);

    assert_off_low_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !en_i[c] |=> !pwm_o[c]);

    assert_stage_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !wr_en_i[c] |=> $stable(stg_i[c]));
  end
endmodule

bind pwm8_dbuf pwm8_dbuf_chk #(.W(W), .CH(CH)) u_pwm8_dbuf_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .cnt_i   (cnt_i),
  .en_i    (en_i),
  .wr_en_i (wr_en_i),
  .pwm_o   (pwm_o),
  .act_i   (act_duty),
  .stg_i   (stg_duty)
);

// File: tb/test_pwm8_dbuf.sv
`timescale 1ns/1ps
module test_pwm8_dbuf;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cnt;
  logic [1:0] en;
  logic [1:0] wr_en;
  logic [7:0] wr_data;
  logic [1:0] pwm;

  int n_vec  = 0;
  int n_fail = 0;
  int m_act[2];
  int m_stg[2];
  int m_prev;
  int hi[2];
  bit m_exp[2];

  always #2.5 clk = ~clk;

  pwm8_dbuf i_pwm8_dbuf (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .cnt_i     (cnt),
    .en_i      (en),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .pwm_o     (pwm)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  // called at a falling edge; drives one timer value and checks the result
  task automatic step(input int c, input logic [1:0] wr, input int d, input string tag);
    bit wrp;
    int eff;
    cnt = c[7:0]; wr_en = wr; wr_data = d[7:0];
    @(posedge clk);
    wrp = (m_prev == 255) && (c == 0);
    for (int k = 0; k < 2; k++) begin
      eff = (wrp && en[k]) ? m_stg[k] : m_act[k];
      m_exp[k] = en[k] && (c >= eff);
      if (wrp && en[k]) m_act[k] = m_stg[k];
      if (wr[k]) m_stg[k] = d;
    end
    m_prev = c;
    @(negedge clk);
    wr_en = '0;
    for (int k = 0; k < 2; k++) begin
      chk(pwm[k] == m_exp[k], (k == 1 && tag == "R2") ? "R9" : tag, pwm[k], m_exp[k]);
      if (pwm[k]) hi[k]++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt = '0; en = '0; wr_en = '0; wr_data = '0;
    m_act = '{0, 0}; m_stg = '{0, 0}; m_prev = 0;
    repeat (3) @(negedge clk);
    chk(pwm == 2'b00, "R1", pwm, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == 2'b00, "R1", pwm, 0);

    // R1: enabled after reset, both registers zero -> high all period
    en = 2'b11;
    hi = '{0, 0};
    for (int c = 0; c < 256; c++) step(c, 2'b00, 0, "R1");
    chk(hi[0] == 256, "R1", hi[0], 256);
    chk(hi[1] == 256, "R1", hi[1], 256);

    // exhaustive duty sweep: stage mid-period (R3), count next period (R2, R5, R9)
    for (int d = 0; d <= 256; d++) begin
      hi = '{0, 0};
      for (int c = 0; c < 256; c++) begin
        if (d < 256 && c == 100)      step(c, 2'b01, d, "R3");
        else if (d < 256 && c == 101) step(c, 2'b10, 255 - d, "R3");
        else                          step(c, 2'b00, 0, (c < 100) ? "R2" : "R3");
      end
      if (d > 0) begin
        chk(hi[0] == 256 - (d - 1), "R5", hi[0], 256 - (d - 1));
        chk(hi[1] == 256 - (255 - (d - 1)), "R9", hi[1], 256 - (255 - (d - 1)));
      end
    end

    // R4 / R7: staged 40, then write 90 on the boundary clock itself
    for (int c = 0; c < 256; c++) step(c, (c == 10) ? 2'b01 : 2'b00, 40, "R4");
    hi = '{0, 0};
    step(0, 2'b01, 90, "R7");
    for (int c = 1; c < 256; c++) step(c, 2'b00, 0, "R7");
    chk(hi[0] == 216, "R7", hi[0], 216);
    hi = '{0, 0};
    for (int c = 0; c < 256; c++) step(c, 2'b00, 0, "R4");
    chk(hi[0] == 166, "R4", hi[0], 166);

    // R6: channel 1 disabled across a boundary, staged write kept, re-enabled mid-period
    en = 2'b01;
    hi = '{0, 0};
    for (int c = 0; c < 256; c++) step(c, (c == 20) ? 2'b10 : 2'b00, 130, "R6");
    for (int c = 0; c < 5; c++) step(c, 2'b00, 0, "R6");
    chk(hi[1] == 0, "R6", hi[1], 0);
    en = 2'b11;
    hi = '{0, 0};
    for (int c = 5; c < 256; c++) step(c, 2'b00, 0, "R6");
    chk(hi[1] == 251, "R6", hi[1], 251);
    hi = '{0, 0};
    for (int c = 0; c < 256; c++) step(c, 2'b00, 0, "R6");
    chk(hi[1] == 126, "R6", hi[1], 126);

    // R8: jump to zero, held top value, held zero
    for (int c = 0; c < 201; c++) step(c, (c == 3) ? 2'b01 : 2'b00, 77, "R8");
    hi = '{0, 0};
    for (int c = 0; c < 256; c++) step(c, 2'b00, 0, "R8");
    chk(hi[0] == 166, "R8", hi[0], 166);
    step(255, 2'b00, 0, "R8");
    step(255, 2'b00, 0, "R8");
    hi = '{0, 0};
    for (int r = 0; r < 3; r++) step(0, 2'b00, 0, "R8");
    for (int c = 1; c < 256; c++) step(c, 2'b00, 0, "R8");
    chk(hi[0] == 179 + 0, "R8", hi[0], 179);

    summary();
    $finish;
  end
endmodule